// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block produces the processor reset for a chip from three sources: power-on, a supply that has dropped below its trip level, and a watchdog that has run out. A digital input reports whether the supply is above the trip level, standing in for the analog comparator. A one-cycle tick input, prescaled outside the block, is the timebase for every interval. The reset is driven out in both polarities, together with a code that reports what caused it.

The reset is only released once the supply has stayed good for a full hold interval. Any dip restarts that interval from zero. While the processor runs, it must keep toggling the chip-select/watchdog-input pin. Only a falling edge on that pin, taken through a two-flop synchronizer, restarts the watchdog. A pin that sits high or sits low for the whole timeout trips a reset, and that reset also lasts one hold interval. A two-bit period code, held in a register outside the block, selects one of three timeouts or turns the watchdog off.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1, `rst_out_n` is 0 and `cause` is 01 (supply).
- R2: With `vdd_ok` held high, reset is released on the clock edge that samples the HOLD_TICKS-th tick pulse, and not before; `cause` then reads 00 (none).
- R3: `rst_out_n` is at all times the inverse of `rst_out`.
- R4: `vdd_ok` low at a clock edge makes `rst_out` 1 and `cause` 01 after that edge.
- R5: A supply dip during the hold interval restarts it: release needs HOLD_TICKS further ticks after the supply returns.
- R6: Period code 10 selects WD_SHORT ticks, 01 selects WD_MID and 00 selects WD_LONG.
- R7: While running with the watchdog enabled, reset is asserted on the edge that samples the tick which completes the selected number of ticks since release or since the last restart, and `cause` becomes 10 (watchdog).
- R8: A watchdog reset lasts HOLD_TICKS ticks, after which reset is released with `cause` 00 and the watchdog counts again from zero.
- R9: A rising edge or a steady level on `wdi` does not restart the watchdog.
- R10: A falling edge on `wdi`, after two synchronizer stages, restarts the watchdog count at zero.
- R11: Period code 11 disables the watchdog: no reset comes from it however long `wdi` stays still.
- R12: Supply low during a watchdog reset changes `cause` to 01 and clears both counters, so release needs a full HOLD_TICKS after the supply returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| vdd_ok | input | 1 | Supply above trip level |
| wdi | input | 1 | Chip-select/watchdog-input pin, asynchronous |
| tick | input | 1 | One-cycle timebase pulse |
| wd_period | input | 2 | Watchdog period code (00 long, 01 mid, 10 short, 11 off) |
| rst_out | output | 1 | Active-high reset |
| rst_out_n | output | 1 | Active-low reset |
| cause | output | 2 | Reset cause: 00 none, 01 supply, 10 watchdog |

## Verification
The hardest case to reach is the exact tick on which the watchdog expires after a stuck pin. It can be hit only when the point of the last falling edge is known, and when a rising edge or a pending synchronizer edge cannot shift the count. The bench drives every tick as a single pulse from a task and lets `wdi` settle for several clocks with no tick between edges. It then counts ticks from release or from a falling edge and checks one tick before and exactly at expiry. The same counting checks the hold interval after a mid-interval supply dip.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_SUPPLY = 2'b01,
        CAUSE_WDOG   = 2'b10
    } cause_t;

    localparam logic [1:0] PERIOD_LONG  = 2'b00;
    localparam logic [1:0] PERIOD_MID   = 2'b01;
    localparam logic [1:0] PERIOD_SHORT = 2'b10;
    localparam logic [1:0] PERIOD_OFF   = 2'b11;
endpackage

// File: rtl/sr_edge_sync.sv
module sr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sr_hold_timer.sv
module sr_hold_timer #(
    parameter int HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int W = $clog2(HOLD_TICKS + 1);
    localparam logic [W-1:0] LAST = W'(HOLD_TICKS - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && !clear_i && tick_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clear_i || !run_i)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = done_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sr_watchdog.sv
module sr_watchdog
    import sup_reset_pkg::*;
#(
    parameter int WD_LONG  = 1400,
    parameter int WD_MID   = 600,
    parameter int WD_SHORT = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       kick_i,
    input  logic       tick_i,
    input  logic [1:0] period_i,
    output logic       expire_o
);
    localparam int MAX_A = (WD_LONG > WD_MID) ? WD_LONG : WD_MID;
    localparam int MAX_L = (MAX_A > WD_SHORT) ? MAX_A : WD_SHORT;
    localparam int W     = $clog2(MAX_L + 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] last;
    logic         active;

    always_comb begin
        case (period_i)
            PERIOD_MID:   last = W'(WD_MID - 1);
            PERIOD_SHORT: last = W'(WD_SHORT - 1);
            default:      last = W'(WD_LONG - 1);
        endcase
        active   = enable_i && (period_i != PERIOD_OFF);
        expire_o = active && !kick_i && tick_i && (cnt_q >= last);
        cnt_d    = cnt_q;
        if (!active || kick_i)
            cnt_d = '0;
        else if (tick_i)
            cnt_d = expire_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_reset_pkg::*;
#(
    parameter int HOLD_TICKS = 200,
    parameter int WD_LONG    = 1400,
    parameter int WD_MID     = 600,
    parameter int WD_SHORT   = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_ok,
    input  logic       wdi,
    input  logic       tick,
    input  logic [1:0] wd_period,
    output logic       rst_out,
    output logic       rst_out_n,
    output logic [1:0] cause
);
    typedef struct packed {
        logic   in_reset;
        cause_t cause;
    } state_t;

    state_t st_d, st_q;
    logic   kick, hold_done, wd_expire;

    sr_edge_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(wdi), .fall_o(kick)
    );

    sr_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
        .clk(clk), .rst_n(rst_n), .clear_i(!vdd_ok), .run_i(st_q.in_reset),
        .tick_i(tick), .done_o(hold_done)
    );

    sr_watchdog #(.WD_LONG(WD_LONG), .WD_MID(WD_MID), .WD_SHORT(WD_SHORT)) i_wd (
        .clk(clk), .rst_n(rst_n), .enable_i(vdd_ok && !st_q.in_reset),
        .kick_i(kick), .tick_i(tick), .period_i(wd_period), .expire_o(wd_expire)
    );

    always_comb begin
        st_d = st_q;
        if (!vdd_ok) begin
            st_d.in_reset = 1'b1;
            st_d.cause    = CAUSE_SUPPLY;
        end else if (hold_done) begin
            st_d.in_reset = 1'b0;
            st_d.cause    = CAUSE_NONE;
        end else if (wd_expire) begin
            st_d.in_reset = 1'b1;
            st_d.cause    = CAUSE_WDOG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.in_reset <= 1'b1;
            st_q.cause    <= CAUSE_SUPPLY;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out   = st_q.in_reset;
    assign rst_out_n = ~st_q.in_reset;
    assign cause     = st_q.cause;
endmodule

// File: rtl/sr_checker.sv
module sr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_ok,
    input logic       tick,
    input logic [1:0] wd_period,
    input logic       rst_out,
    input logic       rst_out_n,
    input logic [1:0] cause
);
    assert_polarity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out_n == !rst_out);

    assert_supply_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vdd_ok |=> (rst_out && cause == 2'b01));

    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> ($past(tick) && $past(vdd_ok) && cause == 2'b00));

    assert_wdog_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_out) && cause == 2'b10) |-> $past(tick));

    assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_period == 2'b11 && vdd_ok && !rst_out) |=> !rst_out);

    assert_cause_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out |-> cause == 2'b00);
endmodule

bind sup_reset_ctrl sr_checker i_chk (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .tick(tick),
    .wd_period(wd_period), .rst_out(rst_out), .rst_out_n(rst_out_n),
    .cause(cause)
);

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
    localparam int HOLD  = 8;
    localparam int LONG  = 12;
    localparam int MID   = 8;
    localparam int SHORT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vdd_ok = 1'b0;
    logic       wdi = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] wd_period = 2'b10;
    logic       rst_out, rst_out_n;
    logic [1:0] cause;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    sup_reset_ctrl #(.HOLD_TICKS(HOLD), .WD_LONG(LONG), .WD_MID(MID), .WD_SHORT(SHORT))
    i_sup_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .wdi(wdi), .tick(tick),
        .wd_period(wd_period), .rst_out(rst_out), .rst_out_n(rst_out_n), .cause(cause)
    );

    task automatic check(string req, logic exp_rst, logic [1:0] exp_cause);
        n_run++;
        if (rst_out !== exp_rst || rst_out_n !== !exp_rst || cause !== exp_cause) begin
            n_fail++;
            $display("FAIL %s: rst=%b rst_n=%b cause=%b, expected rst=%b rst_n=%b cause=%b",
                     req, rst_out, rst_out_n, cause, exp_rst, !exp_rst, exp_cause);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_wdi(logic v);
        @(negedge clk) wdi = v;
        idle(4);
    endtask

    task automatic t_reset_state;
        idle(3);
        check("R1 held in reset", 1'b1, 2'b01);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check("R1 no supply after reset", 1'b1, 2'b01);
    endtask

    task automatic t_power_up;
        @(negedge clk) vdd_ok = 1'b1;
        ticks(HOLD - 1);
        check("R2 before hold end", 1'b1, 2'b01);
        ticks(1);
        check("R2 R3 released", 1'b0, 2'b00);
    endtask

    task automatic t_brownout;
        @(negedge clk) vdd_ok = 1'b0;
        @(negedge clk);
        check("R4 supply low", 1'b1, 2'b01);
        vdd_ok = 1'b1;
        ticks(HOLD - 2);
        @(negedge clk) vdd_ok = 1'b0;
        @(negedge clk) vdd_ok = 1'b1;
        ticks(HOLD - 1);
        check("R5 dip restarts hold", 1'b1, 2'b01);
        ticks(1);
        check("R5 release after full hold", 1'b0, 2'b00);
    endtask

    task automatic t_stuck_low_short;
        wd_period = 2'b10;
        ticks(SHORT - 1);
        check("R6 R7 short not yet", 1'b0, 2'b00);
        ticks(1);
        check("R6 R7 short expiry", 1'b1, 2'b10);
        ticks(HOLD - 1);
        check("R8 wdog hold", 1'b1, 2'b10);
        ticks(1);
        check("R8 wdog release", 1'b0, 2'b00);
    endtask

    task automatic t_stuck_high_mid;
        wd_period = 2'b01;
        ticks(MID - 3);
        set_wdi(1'b1);
        ticks(2);
        check("R9 rising edge ignored", 1'b0, 2'b00);
        ticks(1);
        check("R6 R9 mid expiry", 1'b1, 2'b10);
        ticks(HOLD);
        check("R8 release after mid", 1'b0, 2'b00);
    endtask

    task automatic t_kick_long;
        wd_period = 2'b00;
        ticks(LONG - 1);
        set_wdi(1'b0);
        ticks(LONG - 1);
        check("R10 fall restarts", 1'b0, 2'b00);
        ticks(1);
        check("R6 R10 long expiry", 1'b1, 2'b10);
        ticks(HOLD);
        check("R8 release after long", 1'b0, 2'b00);
    endtask

    task automatic t_disabled;
        wd_period = 2'b11;
        ticks(3 * LONG);
        check("R11 disabled", 1'b0, 2'b00);
    endtask

    task automatic t_supply_override;
        wd_period = 2'b10;
        ticks(SHORT);
        check("R12 wdog first", 1'b1, 2'b10);
        ticks(HOLD - 2);
        @(negedge clk) vdd_ok = 1'b0;
        @(negedge clk);
        check("R12 cause to supply", 1'b1, 2'b01);
        vdd_ok = 1'b1;
        ticks(HOLD - 1);
        check("R12 hold restarted", 1'b1, 2'b01);
        ticks(1);
        check("R12 release", 1'b0, 2'b00);
    endtask

    initial begin
        t_reset_state();
        t_power_up();
        t_brownout();
        t_stuck_low_short();
        t_stuck_high_mid();
        t_kick_long();
        t_disabled();
        t_supply_override();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule